// File: doc/BRIEF.md
# Shared-Pin ROM/RAM Combination Memory

This block is a clock-sampled model of a byte-wide memory that places a read-only array and a smaller read/write array behind one 8-bit data port. Three active-low controls steer it: a ROM select, a write strobe, and one shared pin. That pin is the output enable while the ROM is selected and the RAM select while it is not. The block samples its controls, address and write data on every rising clock edge. From the sampled controls it decodes one of five modes: standby, floating output, ROM read, RAM read and RAM write.

The data port is split into an input byte, an output byte and an output-enable flag, so that the chip level can build a tri-state bus from them. The ROM holds a computed pattern selected by a seed parameter. A RAM write spans the overlap of the shared pin low and the write strobe low. The byte is committed on the clock edge at which that overlap ends. The array depths are parameters.

Top module: `combo_mem`

## Requirements
- R1: During and directly after reset, `dq_oe_o` is 0 and `dq_o` is 0.
- R2: When the sampled ROM select and shared pin are both 1, the mode is standby and `dq_oe_o` is 0, whatever the write strobe and the address are.
- R3: When the sampled ROM select is 0 and the shared pin is 1, the output floats (`dq_oe_o` = 0).
- R4: When the sampled ROM select and shared pin are both 0, `dq_oe_o` is 1 and `dq_o` is the ROM byte, whatever the write strobe is. The ROM byte is the low 8 bits of (index*29 + ROM_SEED), where the index is the address bits below ROM_AW and ROM_SEED defaults to 0x3C.
- R5: When the sampled ROM select is 1, the shared pin is 0 and the write strobe is 1, `dq_oe_o` is 1 and `dq_o` is the RAM byte at the sampled address.
- R6: A write is the overlap of the shared pin at 0 and the write strobe at 0 while the ROM select is 1. It is committed at the first clock edge where the sampled overlap has ended, using the address and data sampled in the last overlap cycle. Either of the two rising edges ends it.
- R7: `dq_oe_o` stays 0 for every cycle that the sampled mode is RAM write.
- R8: A read of a location after its write has ended returns the byte just written.
- R9: RAM address bits at RAM_AW and above have no effect on which byte is read or written.
- R10: The outputs follow the controls sampled at the previous rising edge. `dq_oe_o` drops in the first cycle the sampled mode leaves a read mode.
- R11: While the ROM select is 0, the write strobe never changes the RAM, and the port shows ROM data.
- R12: Whenever `dq_oe_o` is 0, `dq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 19 | Byte address |
| rom_sel_n_i | input | 1 | ROM select, active low |
| oe_ramsel_n_i | input | 1 | Shared pin: ROM output enable or RAM select, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| dq_i | input | 8 | Write data |
| dq_o | output | 8 | Read data, zero when not driven |
| dq_oe_o | output | 1 | Data output enable |

## Verification
The bench ends one write by raising the strobe and another by raising the shared pin. It changes the data in the middle of a write, so a design that commits on the falling edge, or that uses data from after the overlap, reads back the wrong byte. It holds the ROM select low with the strobe low and a different byte on the input. A decoder that ranks a RAM access above the ROM would then corrupt the RAM or drive RAM data. It also reads a byte through an address whose high bits differ from the write address, which exposes decoding of bits that must be ignored. Finally, it checks the output one half-cycle after a control change, before and after the next edge, to pin the latency to one cycle.

// File: rtl/combo_pkg.sv
package combo_pkg;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        MD_STBY,
        MD_FLOAT,
        MD_ROM_RD,
        MD_RAM_RD,
        MD_RAM_WR
    } mode_e;

    typedef struct packed {
        logic              rom_n;
        logic              shr_n;
        logic              wr_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
    } samp_t;

    function automatic logic [DATA_W-1:0] rom_byte(input int unsigned idx,
                                                   input logic [DATA_W-1:0] seed);
        int unsigned v;
        v = idx * 29 + int'(seed);
        return v[DATA_W-1:0];
    endfunction
endpackage

// File: rtl/combo_decode.sv
module combo_decode
    import combo_pkg::*;
(
    input  logic  rom_n_i,
    input  logic  shr_n_i,
    input  logic  wr_n_i,
    output mode_e mode_o
);
    always_comb begin
        if (!rom_n_i) begin
            mode_o = shr_n_i ? MD_FLOAT : MD_ROM_RD;
        end else if (shr_n_i) begin
            mode_o = MD_STBY;
        end else begin
            mode_o = wr_n_i ? MD_RAM_RD : MD_RAM_WR;
        end
    end
endmodule

// File: rtl/combo_rom.sv
module combo_rom
    import combo_pkg::*;
#(
    parameter int              ROM_AW   = 11,
    parameter logic [DATA_W-1:0] ROM_SEED = 8'h3C
) (
    input  logic [ROM_AW-1:0] idx_i,
    output logic [DATA_W-1:0] data_o
);
    always_comb begin
        data_o = rom_byte(int'(idx_i), ROM_SEED);
    end
endmodule

// File: rtl/combo_ram.sv
module combo_ram
    import combo_pkg::*;
#(
    parameter int RAM_AW = 11
) (
    input  logic              clk,
    input  logic              we_i,
    input  logic [RAM_AW-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [RAM_AW-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << RAM_AW;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/combo_mem.sv
module combo_mem
    import combo_pkg::*;
#(
    parameter int                ROM_AW   = 11,
    parameter int                RAM_AW   = 11,
    parameter logic [DATA_W-1:0] ROM_SEED = 8'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rom_sel_n_i,
    input  logic              oe_ramsel_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] dq_i,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe_o
);
    localparam samp_t SAMP_RST = '{rom_n: 1'b1, shr_n: 1'b1, wr_n: 1'b1,
                                   addr: '0, din: '0};

    samp_t             st_d, st_q;
    mode_e             mode_d, mode_q;
    logic              commit;
    logic [DATA_W-1:0] rom_data, ram_data;

    // next-state: capture the pins every edge
    always_comb begin
        st_d       = st_q;
        st_d.rom_n = rom_sel_n_i;
        st_d.shr_n = oe_ramsel_n_i;
        st_d.wr_n  = wr_n_i;
        st_d.addr  = addr_i;
        st_d.din   = dq_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= SAMP_RST;
        end else begin
            st_q <= st_d;
        end
    end

    combo_decode u_dec_q (
        .rom_n_i (st_q.rom_n),
        .shr_n_i (st_q.shr_n),
        .wr_n_i  (st_q.wr_n),
        .mode_o  (mode_q)
    );

    combo_decode u_dec_d (
        .rom_n_i (st_d.rom_n),
        .shr_n_i (st_d.shr_n),
        .wr_n_i  (st_d.wr_n),
        .mode_o  (mode_d)
    );

    // trailing edge of the write overlap
    assign commit = rst_n && (mode_q == MD_RAM_WR) && (mode_d != MD_RAM_WR);

    combo_rom #(
        .ROM_AW   (ROM_AW),
        .ROM_SEED (ROM_SEED)
    ) u_rom (
        .idx_i  (st_q.addr[ROM_AW-1:0]),
        .data_o (rom_data)
    );

    combo_ram #(
        .RAM_AW (RAM_AW)
    ) u_ram (
        .clk     (clk),
        .we_i    (commit),
        .waddr_i (st_q.addr[RAM_AW-1:0]),
        .wdata_i (st_q.din),
        .raddr_i (st_q.addr[RAM_AW-1:0]),
        .rdata_o (ram_data)
    );

    always_comb begin
        dq_oe_o = 1'b0;
        dq_o    = '0;
        unique case (mode_q)
            MD_ROM_RD: begin
                dq_oe_o = 1'b1;
                dq_o    = rom_data;
            end
            MD_RAM_RD: begin
                dq_oe_o = 1'b1;
                dq_o    = ram_data;
            end
            default: begin
                dq_oe_o = 1'b0;
                dq_o    = '0;
            end
        endcase
    end

    AST_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rom_n && st_q.shr_n) |-> !dq_oe_o); // R2
    AST_FLOAT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.rom_n && st_q.shr_n) |-> !dq_oe_o); // R3
    AST_ROM_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.rom_n && !st_q.shr_n) |-> (dq_oe_o && dq_o == rom_data)); // R4
    AST_WRITE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.rom_n && !st_q.shr_n && !st_q.wr_n) |-> !dq_oe_o); // R7
    AST_ROM_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.rom_n |-> !commit); // R11
    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(commit) && mode_q == MD_RAM_RD &&
         st_q.addr[RAM_AW-1:0] == $past(st_q.addr[RAM_AW-1:0]))
        |-> dq_o == $past(st_q.din)); // R8
    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o |-> dq_o == '0); // R12
endmodule

// File: tb/combo_mem_tb_top.sv
module combo_mem_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [18:0] addr = '0;
    logic        rom_n = 1'b1, shr_n = 1'b1, wr_n = 1'b1;
    logic [7:0]  din = '0;
    logic [7:0]  dq;
    logic        oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    combo_mem dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .addr_i        (addr),
        .rom_sel_n_i   (rom_n),
        .oe_ramsel_n_i (shr_n),
        .wr_n_i        (wr_n),
        .dq_i          (din),
        .dq_o          (dq),
        .dq_oe_o       (oe)
    );

    function automatic logic [7:0] exp_rom(input logic [18:0] a);
        int unsigned v;
        v = int'(a[10:0]) * 29 + 32'h3C;
        return v[7:0];
    endfunction

    task automatic chk(input string req, input logic exp_oe, input logic [7:0] exp_dq);
        checks++;
        if (oe !== exp_oe || dq !== exp_dq) begin
            fails++;
            $display("FAIL %s: oe/dq = %b/%h expected %b/%h", req, oe, dq, exp_oe, exp_dq);
        end
    endtask

    task automatic drive(input logic r, input logic s, input logic w,
                         input logic [18:0] a, input logic [7:0] d);
        rom_n = r; shr_n = s; wr_n = w; addr = a; din = d;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 in reset", 1'b0, 8'h00);
        rst_n = 1'b1;
        step();
        chk("R1 after reset", 1'b0, 8'h00);
    endtask

    task automatic t_standby();
        drive(1, 1, 0, 19'h00123, 8'hAA); step();
        chk("R2 standby we low", 1'b0, 8'h00);
        drive(1, 1, 1, 19'h7FFFF, 8'h55); step();
        chk("R2 standby we high, R12", 1'b0, 8'h00);
    endtask

    task automatic t_float();
        drive(0, 1, 1, 19'h00042, 8'h00); step();
        chk("R3 float", 1'b0, 8'h00);
        drive(0, 1, 0, 19'h00042, 8'h00); step();
        chk("R3 float we low", 1'b0, 8'h00);
    endtask

    task automatic t_rom_read();
        drive(0, 0, 1, 19'h00000, 8'h00); step();
        chk("R4 rom idx 0", 1'b1, exp_rom(19'h00000));
        drive(0, 0, 1, 19'h7FFFF, 8'h00); step();
        chk("R4 rom top idx", 1'b1, exp_rom(19'h7FFFF));
        drive(0, 0, 0, 19'h002A7, 8'hEE); step();
        chk("R4 rom we ignored", 1'b1, exp_rom(19'h002A7));
    endtask

    task automatic t_latency();
        drive(0, 0, 1, 19'h00111, 8'h00); step();
        drive(1, 1, 1, 19'h00222, 8'h00);
        #1;
        chk("R10 before edge", 1'b1, exp_rom(19'h00111));
        step();
        chk("R10 after edge", 1'b0, 8'h00);
    endtask

    task automatic t_write_by_we();
        drive(1, 0, 1, 19'h00005, 8'h00); step();
        drive(1, 0, 0, 19'h00005, 8'h3C); step();
        chk("R7 write cycle 1", 1'b0, 8'h00);
        drive(1, 0, 0, 19'h00005, 8'h5D); step();
        chk("R7 write cycle 2", 1'b0, 8'h00);
        drive(1, 0, 1, 19'h00005, 8'hFF); step();
        chk("R6 R8 R5 readback after we rise", 1'b1, 8'h5D);
    endtask

    task automatic t_write_by_cs();
        drive(1, 1, 0, 19'h00123, 8'hA7); step();
        chk("R2 we low first", 1'b0, 8'h00);
        drive(1, 0, 0, 19'h00123, 8'hA7); step();
        chk("R7 cs-started write", 1'b0, 8'h00);
        drive(1, 1, 0, 19'h00123, 8'h00); step();
        chk("R6 cs rise ends write", 1'b0, 8'h00);
        drive(1, 0, 1, 19'h7F923, 8'h00); step();
        chk("R9 upper bits ignored on read", 1'b1, 8'hA7);
        drive(1, 0, 0, 19'h7F805, 8'hC4); step();
        drive(1, 0, 1, 19'h7F805, 8'hC4); step();
        drive(1, 0, 1, 19'h00005, 8'h00); step();
        chk("R9 upper bits ignored on write", 1'b1, 8'hC4);
    endtask

    task automatic t_rom_priority();
        drive(0, 0, 0, 19'h00005, 8'h99); step();
        chk("R11 rom wins cycle 1", 1'b1, exp_rom(19'h00005));
        drive(0, 0, 0, 19'h00005, 8'h77); step();
        chk("R11 rom wins cycle 2", 1'b1, exp_rom(19'h00005));
        drive(1, 1, 1, 19'h00005, 8'h00); step();
        drive(1, 0, 1, 19'h00005, 8'h00); step();
        chk("R11 ram untouched", 1'b1, 8'hC4);
    endtask

    initial begin
        t_reset();
        t_standby();
        t_float();
        t_rom_read();
        t_latency();
        t_write_by_we();
        t_write_by_cs();
        t_rom_priority();
        drive(1, 1, 1, 19'h0, 8'h0); step();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule